// File: doc/BRIEF.md
# Stage Sequencer with Decimating Averager

This block drives one shared capacitance converter through a sequence of conversion stages. A start pulse begins a pass at stage 0. The pass runs up to a programmed last stage, and a field value above the stage count is clamped to the final stage. For each stage the block presents that stage's per-input connection codes on the mux select output. It counts the incoming 16-bit modulator samples and reduces them to one averaged value, which it writes into that stage's result register.

The averaging length is three times a decimation rate chosen by a 2-bit field. The result is the truncated mean of the samples. It is formed by a right shift by log2 of the rate, followed by a reciprocal multiply that divides exactly by three. The last-stage and decimation fields are captured when a pass begins. A start request that arrives during a pass is remembered, and the next pass begins directly after the current one ends.

Top module: `conv_stage_seq`

## Requirements
- R1: After reset all result registers read 0, `stage_o` is 0, `seq_done_o` is low and every 2-bit field of `mux_sel_o` reads 2'b11 (bias).
- R2: A pass visits stages 0, 1, … up to the captured last-stage value in order, shown on `stage_o`. A last-stage value above 7 runs all eight stages. `stage_o` is 0 again once the pass ends.
- R3: The decimation field maps 2'b00 to 256, 2'b01 to 128, and 2'b10 and 2'b11 to 64. A stage ends on exactly its 3 × rate-th accepted sample.
- R4: A stage result equals floor(sum of its samples / (3 × rate)). This holds up to full-scale samples of 65535, with no overflow.
- R5: A stage's result register changes only when that stage completes. The new value is visible in the cycle after the edge that accepts its final sample, and all other result registers hold.
- R6: `seq_done_o` is high for exactly one cycle per pass. That cycle is the one in which the last stage's result first becomes visible.
- R7: While a pass runs, `mux_sel_o` equals the active stage's slice of `mux_cfg_i`, with input n at bits [2n+1:2n]. The codes are 00 floating, 01 negative converter input, 10 positive converter input and 11 bias. While idle, every field reads 11.
- R8: Samples offered while idle, and cycles with `samp_valid_i` low, add nothing to any result.
- R9: A start pulse during a pass is held. The next pass begins at stage 0 right after the current pass ends, with no further start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a pass (held if one is running) |
| samp_valid_i | input | 1 | Modulator sample strobe |
| samp_i | input | 16 | Modulator sample |
| last_stage_i | input | 4 | Index of the final stage in a pass |
| decim_i | input | 2 | Decimation rate select |
| mux_cfg_i | input | 128 | Per-stage, per-input connection codes, stage s at [16s+15:16s] |
| stage_o | output | 3 | Active stage index |
| mux_sel_o | output | 16 | Connection codes applied to the inputs now |
| results_o | output | 128 | Stage results, stage s at [16s+15:16s] |
| seq_done_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
Constant samples per stage show that results land in the right register and that stages advance in the right order. A ramp with a quadratic term leaves non-zero remainders, which separates truncation from rounding and a wrong divisor from a right one. Full-scale constants expose accumulator overflow. Sparse strobes and samples offered while idle show that only accepted samples count. The runs also cover a clamped last stage, every decimation code, and a start request raised mid-pass. Across them the bench compares stage length, mux codes, the moment of each register update and the restart without a second start.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_RUN} seq_state_e;
  localparam logic [1:0] MUX_BIAS = 2'b11;
endpackage

// File: rtl/stage_ctrl.sv
module stage_ctrl
  import seq_pkg::*;
#(
  parameter int NUM_STAGES = 8,
  parameter int LAST_W     = 4,
  localparam int STG_W     = $clog2(NUM_STAGES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LAST_W-1:0] last_stage_i,
  input  logic [1:0]       decim_i,
  input  logic             stage_done_i,
  output logic             run_o,
  output logic [STG_W-1:0] stage_o,
  output logic [1:0]       decim_o,
  output logic             wr_en_o,
  output logic             seq_done_o
);
  localparam logic [LAST_W-1:0] LAST_MAX = LAST_W'(NUM_STAGES - 1);

  seq_state_e       state_q;
  logic [STG_W-1:0] stage_q, last_q, last_eff;
  logic [1:0]       dec_q;
  logic             pend_q, done_q;
  logic             run, end_seq, seq_go;

  assign run      = (state_q == ST_RUN);
  assign last_eff = (last_stage_i > LAST_MAX) ? STG_W'(LAST_MAX) : STG_W'(last_stage_i);
  assign end_seq  = run && stage_done_i && (stage_q == last_q);
  assign seq_go   = (!run && start_i) || (end_seq && (pend_q || start_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      stage_q <= '0;
      last_q  <= '0;
      dec_q   <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= end_seq;
      if (seq_go) begin
        state_q <= ST_RUN;
        stage_q <= '0;
        last_q  <= last_eff;
        dec_q   <= decim_i;
        pend_q  <= 1'b0;
      end else if (end_seq) begin
        state_q <= ST_IDLE;
        stage_q <= '0;
        pend_q  <= 1'b0;
      end else begin
        if (run && stage_done_i) stage_q <= stage_q + 1'b1;
        if (run && start_i)      pend_q  <= 1'b1;
      end
    end
  end

  assign run_o      = run;
  assign stage_o    = stage_q;
  assign decim_o    = dec_q;
  assign wr_en_o    = run && stage_done_i;
  assign seq_done_o = done_q;

  // R2: never past the captured last stage
  a_r2_stage_le_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> stage_q <= last_q);
  // R6: done is a single-cycle pulse
  a_r6_single_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |=> !seq_done_o);
  // R9: held request restarts immediately
  a_r9_pend_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_seq && pend_q) |=> (run && stage_q == '0));
endmodule

// File: rtl/sample_avg.sv
module sample_avg #(
  parameter int SAMP_W      = 16,
  parameter int DEC_LOG_MAX = 8,
  localparam int CNT_W      = $clog2(3 * (1 << DEC_LOG_MAX)),
  localparam int ACC_W      = SAMP_W + CNT_W,
  localparam int SH_W       = $clog2(DEC_LOG_MAX + 1),
  localparam int QIN_W      = SAMP_W + 2,
  localparam int DIV_SH     = SAMP_W + 3,
  localparam int PROD_W     = QIN_W + DIV_SH + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [SAMP_W-1:0] samp_i,
  input  logic [1:0]        decim_i,
  output logic              done_o,
  output logic [SAMP_W-1:0] avg_o
);
  // ceil(2^DIV_SH / 3): exact floor division by 3 for inputs below 2^QIN_W
  localparam logic [PROD_W-1:0] RECIP = PROD_W'(((64'd1 << DIV_SH) / 64'd3) + 64'd1);

  logic [ACC_W-1:0]  acc_q, sum;
  logic [CNT_W-1:0]  cnt_q, last_cnt;
  logic [SH_W-1:0]   sh;
  logic [QIN_W-1:0]  shifted;
  logic [PROD_W-1:0] prod;
  logic              take;

  always_comb begin
    unique case (decim_i)
      2'b00:   sh = SH_W'(DEC_LOG_MAX);
      2'b01:   sh = SH_W'(DEC_LOG_MAX - 1);
      default: sh = SH_W'(DEC_LOG_MAX - 2);
    endcase
    last_cnt = CNT_W'((32'd3 << sh) - 32'd1);
  end

  assign take    = en_i && valid_i;
  assign done_o  = take && (cnt_q == last_cnt);
  assign sum     = acc_q + ACC_W'(samp_i);
  assign shifted = QIN_W'(sum >> sh);
  assign prod    = PROD_W'(shifted) * RECIP;
  assign avg_o   = SAMP_W'(prod >> DIV_SH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      if (done_o) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= sum;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R8: nothing accumulates without an accepted sample
  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> (acc_q == $past(acc_q) && cnt_q == $past(cnt_q)));
  // R3: counter stays inside the stage length
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= last_cnt);
endmodule

// File: rtl/result_bank.sv
module result_bank #(
  parameter int NUM_STAGES = 8,
  parameter int SAMP_W     = 16,
  localparam int STG_W     = $clog2(NUM_STAGES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [STG_W-1:0]             wr_idx_i,
  input  logic [SAMP_W-1:0]            wr_data_i,
  output logic [NUM_STAGES*SAMP_W-1:0] results_o
);
  logic [NUM_STAGES-1:0] wr_sel;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_slot
    logic [SAMP_W-1:0] res_q;
    assign wr_sel[i] = wr_en_i && (wr_idx_i == STG_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        res_q <= '0;
      else if (wr_sel[i]) res_q <= wr_data_i;
    end
    assign results_o[i*SAMP_W +: SAMP_W] = res_q;
  end

  // R5: at most one slot written, and nothing moves without a write
  a_r5_one_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(results_o));
endmodule

// File: rtl/conv_stage_seq.sv
module conv_stage_seq
  import seq_pkg::*;
#(
  parameter int NUM_STAGES  = 8,
  parameter int NUM_INPUTS  = 8,
  parameter int SAMP_W      = 16,
  parameter int LAST_W      = 4,
  parameter int DEC_LOG_MAX = 8,
  localparam int STG_W      = $clog2(NUM_STAGES),
  localparam int MUX_W      = 2 * NUM_INPUTS
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         samp_valid_i,
  input  logic [SAMP_W-1:0]            samp_i,
  input  logic [LAST_W-1:0]            last_stage_i,
  input  logic [1:0]                   decim_i,
  input  logic [NUM_STAGES*MUX_W-1:0]  mux_cfg_i,
  output logic [STG_W-1:0]             stage_o,
  output logic [MUX_W-1:0]             mux_sel_o,
  output logic [NUM_STAGES*SAMP_W-1:0] results_o,
  output logic                         seq_done_o
);
  logic              run, stage_done, wr_en;
  logic [1:0]        dec_act;
  logic [SAMP_W-1:0] avg;

  stage_ctrl #(.NUM_STAGES(NUM_STAGES), .LAST_W(LAST_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .last_stage_i, .decim_i,
    .stage_done_i(stage_done), .run_o(run), .stage_o, .decim_o(dec_act),
    .wr_en_o(wr_en), .seq_done_o
  );

  sample_avg #(.SAMP_W(SAMP_W), .DEC_LOG_MAX(DEC_LOG_MAX)) u_avg (
    .clk_i, .rst_ni, .en_i(run), .valid_i(samp_valid_i), .samp_i,
    .decim_i(dec_act), .done_o(stage_done), .avg_o(avg)
  );

  result_bank #(.NUM_STAGES(NUM_STAGES), .SAMP_W(SAMP_W)) u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(stage_o),
    .wr_data_i(avg), .results_o
  );

  assign mux_sel_o = run ? mux_cfg_i[stage_o*MUX_W +: MUX_W] : {NUM_INPUTS{MUX_BIAS}};

  // R2: a finished pass leaves the stage index at 0
  a_r2_home_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |-> stage_o == '0);
endmodule

// File: tb/conv_stage_seq_test.sv
module conv_stage_seq_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         samp_valid_i = 1'b0;
  logic [15:0]  samp_i = '0;
  logic [3:0]   last_stage_i = '0;
  logic [1:0]   decim_i = '0;
  logic [127:0] mux_cfg_i;
  logic [2:0]   stage_o;
  logic [15:0]  mux_sel_o;
  logic [127:0] results_o;
  logic         seq_done_o;

  int checks = 0;
  int errors = 0;
  longint exp_res [8];

  always #4 clk_i = ~clk_i;

  conv_stage_seq uut (.*);

  function automatic logic [15:0] exp_mux(input int s);
    logic [15:0] m;
    for (int n = 0; n < 8; n++) m[n*2 +: 2] = 2'((s * 3 + n) % 4);
    return m;
  endfunction

  function automatic logic [15:0] samp_val(input int pat, input int base, input int s, input int j);
    if (pat == 0) return 16'(base + s * 1000);
    return 16'(base + s * 4099 + j * 37 + (j * j) % 501);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one pass: R2 R3 R4 R5 R6 R7, optional held start (R9) and gaps (R8)
  task automatic run_seq(input int last, input int dec, input int pat, input int base,
                         input bit gap, input bit do_start, input bit mid_start);
    int nst, cnt;
    nst = (last > 7) ? 8 : last + 1;
    cnt = 3 * ((dec == 0) ? 256 : (dec == 1) ? 128 : 64);
    last_stage_i = 4'(last);
    decim_i = 2'(dec);
    if (do_start) begin
      @(negedge clk_i);
      start_i = 1'b1;
      samp_valid_i = 1'b0;
    end
    for (int s = 0; s < nst; s++) begin
      longint sum = 0;
      bit bad = 0;
      for (int j = 0; j < cnt; j++) begin
        if (gap && (j % 2 == 1)) begin
          @(negedge clk_i);
          start_i = 1'b0;
          samp_valid_i = 1'b0;
          samp_i = 16'hFFFF;
        end
        @(negedge clk_i);
        if (j == 0) begin
          chk(results_o[s*16 +: 16] == 16'(exp_res[s]), "R5 slot holds old value",
              longint'(results_o[s*16 +: 16]), exp_res[s]);
          if (s > 0)
            chk(results_o[(s-1)*16 +: 16] == 16'(exp_res[s-1]), "R5 slot updated after stage",
                longint'(results_o[(s-1)*16 +: 16]), exp_res[s-1]);
        end
        if (stage_o != 3'(s) || mux_sel_o != exp_mux(s) || seq_done_o) bad = 1;
        start_i = mid_start && s == 0 && j == 5;
        samp_valid_i = 1'b1;
        samp_i = samp_val(pat, base, s, j);
        sum += longint'(samp_i);
      end
      // R2 R3 R7: stage index, length and mux codes held across the whole stage
      chk(!bad, "R2 R3 R7 stage walk", longint'(stage_o), s);
      exp_res[s] = sum / cnt;
    end
    @(negedge clk_i);
    samp_valid_i = 1'b0;
    start_i = 1'b0;
    chk(seq_done_o == 1'b1, "R6 done with last result", seq_done_o, 1);
    for (int k = 0; k < 8; k++)
      chk(results_o[k*16 +: 16] == 16'(exp_res[k]), "R4 stage result",
          longint'(results_o[k*16 +: 16]), exp_res[k]);
    if (!mid_start) begin
      chk(mux_sel_o == 16'hFFFF, "R7 idle bias", longint'(mux_sel_o), 16'hFFFF);
      chk(stage_o == 3'd0, "R2 stage home", longint'(stage_o), 0);
    end
    @(negedge clk_i);
    chk(seq_done_o == 1'b0, "R6 single pulse", seq_done_o, 0);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 8; k++) begin
      exp_res[k] = 0;
      chk(results_o[k*16 +: 16] == 16'd0, "R1 result reset", longint'(results_o[k*16 +: 16]), 0);
    end
    chk(stage_o == 3'd0 && !seq_done_o, "R1 stage/done reset", longint'(stage_o), 0);
    chk(mux_sel_o == 16'hFFFF, "R1 mux reset bias", longint'(mux_sel_o), 16'hFFFF);
  endtask

  task automatic t_idle_samples;
    // R8: samples while idle must not leak into the next pass
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      samp_valid_i = 1'b1;
      samp_i = 16'hFFFF;
    end
    @(negedge clk_i);
    samp_valid_i = 1'b0;
    chk(!seq_done_o && stage_o == 3'd0, "R8 idle samples ignored", longint'(stage_o), 0);
    run_seq(2, 2, 1, 777, 0, 1, 0);
  endtask

  task automatic t_pending;
    // R9: start raised mid-pass, second pass runs without another start
    run_seq(1, 2, 0, 3000, 0, 1, 1);
    chk(stage_o == 3'd0 && mux_sel_o == exp_mux(0), "R9 restarted pass",
        longint'(mux_sel_o), longint'(exp_mux(0)));
    run_seq(1, 2, 1, 50, 0, 0, 0);
  endtask

  initial begin
    for (int s = 0; s < 8; s++) mux_cfg_i[s*16 +: 16] = exp_mux(s);
    #20;
    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    run_seq(1, 2, 0, 1000, 0, 1, 0);   // constant per stage, rate 64
    run_seq(5, 1, 1, 12345, 1, 1, 0);  // ramp, rate 128, sparse strobes (R8)
    run_seq(0, 0, 0, 65535, 0, 1, 0);  // full scale, rate 256 (R4)
    run_seq(0, 0, 1, 9, 0, 1, 0);      // remainders, rate 256 (R4 truncation)
    run_seq(15, 3, 1, 400, 0, 1, 0);   // clamp to 8 stages, code 11 (R2 R3)
    t_idle_samples();
    t_pending();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule